// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steers a small processor subsystem into and out of its power-down states. A single sleep strobe from the CPU leads to one of three modes, chosen by configuration bits. Sleep stops only the CPU clock. Deep sleep also stops the external clock output. Standby stops the CPU clock, every peripheral clock lane and the external clock output. On entry to standby it also sends a one-cycle initialization pulse to the peripheral registers that lose their contents.

Standby is granted only when the watchdog is safe and no DMA transfer is in flight. When a DMA transfer blocks the request, a sticky error flag records it. The two status pins show the current mode to the board. An interrupt ends sleep or deep sleep at once. Standby ends only after the oscillator reports that it is stable again. The block never resets the CPU or its cache.

Top module: `lpm_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters running mode. In running mode `cpu_clk_en`=1, every `per_clk_en` bit is 1, `ckout_en`=1, `status`=00, `dma_err`=0, `per_init_pulse`=0 and `tmr_start_init`=0.
- R2: In running mode, a `sleep_req` with `cfg_standby`=0 and `cfg_deep`=0 enters sleep at the next edge. In sleep `cpu_clk_en`=0, all `per_clk_en`=1, `ckout_en`=1 and `status`=10.
- R3: In running mode, a `sleep_req` with `cfg_standby`=0 and `cfg_deep`=1 enters deep sleep. In deep sleep `cpu_clk_en`=0, all `per_clk_en`=1, `ckout_en`=0 and `status`=11.
- R4: In running mode, a `sleep_req` with `cfg_standby`=1 enters standby when the guards of R6 and R7 are met. In standby `cpu_clk_en`=0, all `per_clk_en`=0, `ckout_en`=0 and `status`=01 (bit 1 low, bit 0 high).
- R5: On standby entry, `per_init_pulse` is 1 for exactly the first standby cycle. `tmr_start_init` is 1 in that same cycle only if `rtc_in_use` was 0 when the strobe was taken.
- R6: A standby request made while `wdt_enable`=1, or while `wdt_preset_loaded`=0, is refused and the block stays running.
- R7: A standby request made while `dma_busy`=1 is refused and sets `dma_err`. `dma_err` then holds until an edge where `err_clear`=1. A new error at that same edge wins over the clear.
- R8: Sleep and deep sleep return to running mode at the next edge when any of these is seen: `nmi`, a nonzero `irl_level`, or a `periph_irq` bit whose `periph_irq_en` bit is set. A peripheral interrupt whose enable bit is clear has no effect.
- R9: In standby, a wake source moves the block to an oscillator-wait state. In that state the clocks stay off and `status` stays 01. The block returns to running mode at the edge where `osc_stable`=1.
- R10: Reset from any mode forces running mode with the outputs of R1.
- R11: `sleep_req` has no effect unless the block is in running mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also a wake source |
| sleep_req | input | 1 | One-cycle strobe from the sleep instruction |
| cfg_standby | input | 1 | Selects standby for the next strobe |
| cfg_deep | input | 1 | Selects deep sleep over sleep when standby is not selected |
| wdt_enable | input | 1 | Watchdog counting enable as currently programmed |
| wdt_preset_loaded | input | 1 | Watchdog preset count has been written |
| rtc_in_use | input | 1 | Realtime clock is using the timer; spares the timer start register |
| dma_busy | input | 1 | A DMA transfer is in progress |
| err_clear | input | 1 | Clears the sticky DMA error flag |
| nmi | input | 1 | Non-maskable interrupt |
| irl_level | input | IRLW | Encoded external interrupt level, zero when idle |
| periph_irq | input | NP | Peripheral interrupt requests |
| periph_irq_en | input | NP | Per-peripheral wake enables |
| osc_stable | input | 1 | Oscillator has settled after standby |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | NP | Peripheral clock lane enables |
| ckout_en | output | 1 | External clock output enable |
| status | output | 2 | Mode code on the status pins |
| per_init_pulse | output | 1 | Initialization pulse to peripheral registers |
| tmr_start_init | output | 1 | Initialization pulse to the timer start register |
| dma_err | output | 1 | Sticky flag: standby refused because of DMA |

## Verification
All outputs are decoded from the mode register. A wrong state therefore shows on the status pins and the clock enables at the first sample after the faulty edge. A state that skips the oscillator wait shows as clocks coming back while `osc_stable` is low. A mis-timed or missing initialization pulse shows in the single cycle after entry. A broken guard shows as a standby code where running mode was expected. A bench model runs alongside the block under random and directed stimulus and compares every output in every cycle.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power sequencer.
// Assumes: one mode register; all outputs are decoded from it.
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_DEEP  = 3'd2,
        ST_STBY  = 3'd3,
        ST_OSCW  = 3'd4
    } lpm_state_e;

    localparam logic [1:0] STAT_RUN   = 2'b00;
    localparam logic [1:0] STAT_SLEEP = 2'b10;
    localparam logic [1:0] STAT_DEEP  = 2'b11;
    localparam logic [1:0] STAT_STBY  = 2'b01;
endpackage

// File: rtl/lpm_wake.sv
// Merges every wake source into one request.
// Assumes: the sources are already synchronous to clk; irl_level is zero when idle.
module lpm_wake #(
    parameter int NP   = 8,
    parameter int IRLW = 4
) (
    input  logic            nmi,
    input  logic [IRLW-1:0] irl_level,
    input  logic [NP-1:0]   periph_irq,
    input  logic [NP-1:0]   periph_irq_en,
    output logic            wake_any
);
    logic [NP-1:0] lane_hit;

    // Qualify each peripheral request with its own enable.
    for (genvar g = 0; g < NP; g++) begin : g_lane
        assign lane_hit[g] = periph_irq[g] & periph_irq_en[g];
    end

    // Any enabled source wakes the block.
    always_comb wake_any = nmi | (|irl_level) | (|lane_hit);
endmodule

// File: rtl/lpm_ctrl.sv
// Mode state machine, standby guards, init pulse and sticky DMA error.
// Assumes: sleep_req is a strobe; a synchronous active-low reset forces running mode.
module lpm_ctrl
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       cfg_standby,
    input  logic       cfg_deep,
    input  logic       wdt_enable,
    input  logic       wdt_preset_loaded,
    input  logic       rtc_in_use,
    input  logic       dma_busy,
    input  logic       err_clear,
    input  logic       wake_any,
    input  logic       osc_stable,
    output lpm_state_e state,
    output logic       init_pulse,
    output logic       tmr_init,
    output logic       dma_err
);
    lpm_state_e nxt;
    logic       stby_req, stby_ok, err_set;

    // Standby request and its guards.
    always_comb begin
        stby_req = (state == ST_RUN) && sleep_req && cfg_standby;
        err_set  = stby_req && dma_busy;
        stby_ok  = stby_req && !dma_busy && !wdt_enable && wdt_preset_loaded;
    end

    // Next mode.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (sleep_req) begin
                    if (cfg_standby) begin
                        if (stby_ok) nxt = ST_STBY;
                    end else if (cfg_deep) begin
                        nxt = ST_DEEP;
                    end else begin
                        nxt = ST_SLEEP;
                    end
                end
            end
            ST_SLEEP, ST_DEEP: if (wake_any) nxt = ST_RUN;
            ST_STBY:           if (wake_any) nxt = ST_OSCW;
            ST_OSCW:           if (osc_stable) nxt = ST_RUN;
            default:           nxt = ST_RUN;
        endcase
    end

    // Mode register and one-cycle entry pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            init_pulse <= 1'b0;
            tmr_init   <= 1'b0;
        end else begin
            state      <= nxt;
            init_pulse <= stby_ok;
            tmr_init   <= stby_ok && !rtc_in_use;
        end
    end

    // Sticky DMA error; a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          dma_err <= 1'b0;
        else if (err_set)    dma_err <= 1'b1;
        else if (err_clear)  dma_err <= 1'b0;
    end

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);
    assert_pulse_on_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |-> (state == ST_STBY) && ($past(state) == ST_RUN));
    assert_wdt_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && sleep_req && cfg_standby && (wdt_enable || !wdt_preset_loaded))
        |=> state == ST_RUN);
    assert_dma_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && sleep_req && cfg_standby && dma_busy) |=> (state == ST_RUN) && dma_err);
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_err && !err_clear) |=> dma_err);
    assert_wake_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_SLEEP) || (state == ST_DEEP)) && wake_any) |=> state == ST_RUN);
    assert_stby_no_direct_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY) |=> state != ST_RUN);
    assert_osc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_OSCW) && !osc_stable) |=> state == ST_OSCW);
endmodule

// File: rtl/lpm_outdec.sv
// Decodes the mode into clock enables and status pin code.
// Assumes: purely combinational; one enable per peripheral lane.
module lpm_outdec
    import lpm_pkg::*;
#(
    parameter int NP = 8
) (
    input  lpm_state_e    state,
    output logic          cpu_clk_en,
    output logic [NP-1:0] per_clk_en,
    output logic          ckout_en,
    output logic [1:0]    status
);
    logic per_on;

    // Mode to CPU clock, external clock and status code.
    always_comb begin
        cpu_clk_en = 1'b0;
        ckout_en   = 1'b0;
        per_on     = 1'b0;
        status     = STAT_STBY;
        unique case (state)
            ST_RUN:   begin cpu_clk_en = 1'b1; ckout_en = 1'b1; per_on = 1'b1; status = STAT_RUN;   end
            ST_SLEEP: begin ckout_en = 1'b1; per_on = 1'b1; status = STAT_SLEEP; end
            ST_DEEP:  begin per_on = 1'b1; status = STAT_DEEP; end
            default:  begin status = STAT_STBY; end
        endcase
    end

    // One gate enable per peripheral lane.
    for (genvar g = 0; g < NP; g++) begin : g_per
        assign per_clk_en[g] = per_on;
    end
endmodule

// File: rtl/lpm_sequencer.sv
// Top of the low-power mode sequencer: wake merge, mode control, output decode.
// Assumes: all inputs synchronous to clk; the reset is synchronous and active low.
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int NP   = 8,
    parameter int IRLW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic            cfg_standby,
    input  logic            cfg_deep,
    input  logic            wdt_enable,
    input  logic            wdt_preset_loaded,
    input  logic            rtc_in_use,
    input  logic            dma_busy,
    input  logic            err_clear,
    input  logic            nmi,
    input  logic [IRLW-1:0] irl_level,
    input  logic [NP-1:0]   periph_irq,
    input  logic [NP-1:0]   periph_irq_en,
    input  logic            osc_stable,
    output logic            cpu_clk_en,
    output logic [NP-1:0]   per_clk_en,
    output logic            ckout_en,
    output logic [1:0]      status,
    output logic            per_init_pulse,
    output logic            tmr_start_init,
    output logic            dma_err
);
    logic       wake_any;
    lpm_state_e state;

    lpm_wake #(.NP(NP), .IRLW(IRLW)) u_wake (
        .nmi(nmi), .irl_level(irl_level), .periph_irq(periph_irq),
        .periph_irq_en(periph_irq_en), .wake_any(wake_any)
    );

    lpm_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cfg_standby(cfg_standby),
        .cfg_deep(cfg_deep), .wdt_enable(wdt_enable), .wdt_preset_loaded(wdt_preset_loaded),
        .rtc_in_use(rtc_in_use), .dma_busy(dma_busy), .err_clear(err_clear),
        .wake_any(wake_any), .osc_stable(osc_stable), .state(state),
        .init_pulse(per_init_pulse), .tmr_init(tmr_start_init), .dma_err(dma_err)
    );

    lpm_outdec #(.NP(NP)) u_dec (
        .state(state), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .ckout_en(ckout_en), .status(status)
    );

    assert_stby_clocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_STBY) |-> !cpu_clk_en && (per_clk_en == '0) && !ckout_en);
    assert_sleep_only_from_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status == STAT_SLEEP) |-> $past(cpu_clk_en));
endmodule

// File: tb/test_lpm_sequencer.sv
module test_lpm_sequencer;
    localparam int NP   = 8;
    localparam int IRLW = 4;

    logic clk = 1'b0;
    logic rst_n, sleep_req, cfg_standby, cfg_deep, wdt_enable, wdt_preset_loaded;
    logic rtc_in_use, dma_busy, err_clear, nmi, osc_stable;
    logic [IRLW-1:0] irl_level;
    logic [NP-1:0]   periph_irq, periph_irq_en;
    logic cpu_clk_en, ckout_en, per_init_pulse, tmr_start_init, dma_err;
    logic [NP-1:0] per_clk_en;
    logic [1:0] status;

    int tests = 0, fails = 0;
    // bench model: 0 run, 1 sleep, 2 deep, 3 standby, 4 oscillator wait
    int m_state = 0;
    logic m_err = 1'b0, m_pulse = 1'b0, m_tmr = 1'b0;

    always #2.5 clk = ~clk;

    lpm_sequencer #(.NP(NP), .IRLW(IRLW)) i_lpm_sequencer (.*);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_status(int s);
        case (s)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic string mode_tag(int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R9";
        endcase
    endfunction

    task automatic idle();
        rst_n = 1'b1; sleep_req = 1'b0; cfg_standby = 1'b0; cfg_deep = 1'b0;
        wdt_enable = 1'b0; wdt_preset_loaded = 1'b1; rtc_in_use = 1'b0;
        dma_busy = 1'b0; err_clear = 1'b0; nmi = 1'b0; irl_level = '0;
        periph_irq = '0; periph_irq_en = '0; osc_stable = 1'b0;
    endtask

    // Advance one cycle: predict from current inputs, then check all outputs.
    task automatic cyc(string tag);
        int ns = m_state;
        logic wake = nmi | (irl_level != 0) | ((periph_irq & periph_irq_en) != 0);
        logic nerr = m_err, np = 1'b0, nt = 1'b0;
        if (err_clear) nerr = 1'b0;
        case (m_state)
            0: if (sleep_req) begin
                if (cfg_standby) begin
                    if (dma_busy) nerr = 1'b1;
                    else if (!wdt_enable && wdt_preset_loaded) begin
                        ns = 3; np = 1'b1; nt = !rtc_in_use;
                    end
                end else ns = cfg_deep ? 2 : 1;
            end
            1, 2: if (wake) ns = 0;
            3: if (wake) ns = 4;
            default: if (osc_stable) ns = 0;
        endcase
        if (!rst_n) begin ns = 0; nerr = 1'b0; np = 1'b0; nt = 1'b0; end
        @(posedge clk);
        @(negedge clk);
        m_state = ns; m_err = nerr; m_pulse = np; m_tmr = nt;
        chk(tag, "status", status, exp_status(m_state));
        chk(tag, "cpu_clk_en", cpu_clk_en, m_state == 0);
        chk(tag, "per_clk_en", per_clk_en, (m_state < 3) ? {NP{1'b1}} : '0);
        chk(tag, "ckout_en", ckout_en, (m_state == 0) || (m_state == 1));
        chk(tag, "per_init_pulse", per_init_pulse, m_pulse);
        chk(tag, "tmr_start_init", tmr_start_init, m_tmr);
        chk(tag, "dma_err", dma_err, m_err);
    endtask

    initial begin
        #1000000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst_n = 1'b1;
        cyc("R1");
        // sleep, strobe ignored while asleep, wake by nmi
        sleep_req = 1'b1; cyc("R2");
        cfg_standby = 1'b1; cyc("R11");
        sleep_req = 1'b0; cfg_standby = 1'b0; cyc("R2");
        nmi = 1'b1; cyc("R8"); nmi = 1'b0;
        // deep sleep, masked periph irq ignored, irl wakes
        sleep_req = 1'b1; cfg_deep = 1'b1; cyc("R3"); sleep_req = 1'b0;
        periph_irq = 8'h10; periph_irq_en = 8'hEF; cyc("R8"); cyc("R8");
        periph_irq = 8'h00; irl_level = 4'h3; cyc("R8"); irl_level = '0;
        // deep sleep woken by enabled periph irq
        sleep_req = 1'b1; cyc("R3"); sleep_req = 1'b0; cfg_deep = 1'b0;
        periph_irq = 8'h04; periph_irq_en = 8'h04; cyc("R8");
        periph_irq = '0; periph_irq_en = '0;
        // watchdog guards
        sleep_req = 1'b1; cfg_standby = 1'b1; wdt_enable = 1'b1; cyc("R6");
        wdt_enable = 1'b0; wdt_preset_loaded = 1'b0; cyc("R6");
        wdt_preset_loaded = 1'b1;
        // DMA guard and sticky error; set wins over clear
        dma_busy = 1'b1; cyc("R7");
        sleep_req = 1'b0; dma_busy = 1'b0; cyc("R7");
        sleep_req = 1'b1; dma_busy = 1'b1; err_clear = 1'b1; cyc("R7");
        sleep_req = 1'b0; dma_busy = 1'b0; cyc("R7");
        err_clear = 1'b0;
        // standby entry with timer init, oscillator wait
        rtc_in_use = 1'b0; sleep_req = 1'b1; cyc("R5"); sleep_req = 1'b0;
        cyc("R5"); cyc("R4");
        nmi = 1'b1; cyc("R9"); nmi = 1'b0;
        repeat (4) cyc("R9");
        osc_stable = 1'b1; cyc("R9"); osc_stable = 1'b0;
        // standby entry with RTC in use: timer register spared
        rtc_in_use = 1'b1; sleep_req = 1'b1; cyc("R5"); sleep_req = 1'b0;
        irl_level = 4'h1; cyc("R9"); irl_level = '0;
        // reset from oscillator wait and from deep sleep
        rst_n = 1'b0; cyc("R10"); rst_n = 1'b1;
        cfg_standby = 1'b0; cfg_deep = 1'b1; sleep_req = 1'b1; cyc("R3"); sleep_req = 1'b0;
        rst_n = 1'b0; cyc("R10"); rst_n = 1'b1; cyc("R10");
        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            rst_n             = ($urandom % 100) != 0;
            sleep_req         = ($urandom % 6) == 0;
            cfg_standby       = ($urandom % 2) == 0;
            cfg_deep          = ($urandom % 2) == 0;
            wdt_enable        = ($urandom % 4) == 0;
            wdt_preset_loaded = ($urandom % 4) != 0;
            rtc_in_use        = ($urandom % 2) == 0;
            dma_busy          = ($urandom % 5) == 0;
            err_clear         = ($urandom % 10) == 0;
            nmi               = ($urandom % 25) == 0;
            irl_level         = (($urandom % 12) == 0) ? IRLW'($urandom) : '0;
            periph_irq        = (($urandom % 8) == 0) ? NP'($urandom) : '0;
            periph_irq_en     = NP'($urandom);
            osc_stable        = ($urandom % 4) == 0;
            cyc(mode_tag(m_state));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule